// File: doc/BRIEF.md
# Linked ROM Entry Walker

This block walks the chain of variable-length entries stored after the header of a device configuration ROM image. It reads the image one byte at a time through a synchronous read port, and the data for a read returns one cycle after the read is issued. A start pulse loads three things: the end of the image, which is the data-length input plus 13; a maximum port index; and a header mode. The header mode sets where the walk begins: offset 22 for the long header, offset 16 for the short header.

The first byte of each entry is its length, and that length counts the two header bytes. The second byte holds the index in bits 5:0, a disabled flag in bit 6 and a type bit in bit 7 (1 = port, 0 = generic). For every accepted entry the block pulses a report carrying the entry's position, length, type, index and disabled flag. For enabled port entries the report also carries the link-number bit (bit 4 of byte 2) and the dual-link bit (bit 7 of byte 2). The walk then moves forward by the entry length. It ends with a done flag when the position reaches the end, or with an error flag when the chain breaks its bounds or a port entry has the wrong size.

Top module: `rom_entry_walker`

## Requirements
- R1: A start accepted with `short_hdr_i`=0 begins the walk at offset 22. With `short_hdr_i`=1 it begins at offset 16.
- R2: The end of the image is `data_len_i`+13. When the current position is at or beyond the end, the walk stops and `done_o` is set. If the first position is already at or beyond the end, no entry is reported.
- R3: Byte 0 of an entry is its length, including the 2 header bytes. Byte 1 bits 5:0 give the index, bit 6 gives the disabled flag, and bit 7 gives the type (1 = port). A report shows these values on `ent_idx_o`, `ent_dis_o` and `ent_port_o`.
- R4: The walk stops with `error_o`=1 and `err_badlen_o`=0 if any of these holds: the entry starts at the last byte (position+1 = end), its length is 0, or position+length exceeds the end. No entry is reported after that.
- R5: A port entry whose index is greater than the latched maximum port index is not reported. No length rule is applied to it, and the walk continues past it.
- R6: An enabled port entry with a length other than 8 stops the walk with `error_o`=1 and `err_badlen_o`=1. A disabled port entry is reported whatever its length.
- R7: For an enabled port entry, `ent_link_o` is bit 4 of byte 2 and `ent_dual_o` is bit 7 of byte 2. For every other reported entry both are 0.
- R8: Entries are reported in chain order. The next position is the current position plus the current length.
- R9: `done_o`, `error_o` and `err_badlen_o` hold until the next accepted start, and that start clears them. A start while `busy_o`=1 is ignored.
- R10: The read of a byte is issued with `mem_rd_o` and `mem_addr_o` in one cycle. The byte is taken from `mem_data_i` in the next cycle.
- R11: After reset, `busy_o`, `done_o`, `error_o` and `ent_valid_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a walk (ignored while busy) |
| short_hdr_i | input | 1 | 1: walk starts at 16, 0: at 22 |
| data_len_i | input | LEN_W | Image data length; end = value + 13 |
| max_port_i | input | 6 | Highest port index accepted |
| mem_rd_o | output | 1 | Read request |
| mem_addr_o | output | LEN_W+1 | Read address |
| mem_data_i | input | 8 | Read data, one cycle after request |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | Walk finished normally (held) |
| error_o | output | 1 | Walk aborted (held) |
| err_badlen_o | output | 1 | Abort cause: 1 port size, 0 overrun |
| ent_valid_o | output | 1 | One-cycle entry report strobe |
| ent_pos_o | output | LEN_W+1 | Entry start position |
| ent_len_o | output | 8 | Entry length |
| ent_port_o | output | 1 | Entry type is port |
| ent_idx_o | output | 6 | Entry index |
| ent_dis_o | output | 1 | Entry disabled flag |
| ent_link_o | output | 1 | Port link-number bit |
| ent_dual_o | output | 1 | Port dual-link flag |

## Verification
Two things can land in the same cycle. The first is a start arriving while a finished walk still holds `done_o` or `error_o`. That start has to clear the held flag and load the new walk at the same time. The bench runs walks back to back, changing the header mode between them. It checks that the held flag survives idle cycles, that it drops in the cycle after the start, and that the next result matches a model computed in the bench. The second is a start pulse that arrives in the middle of a walk. The walk must ignore it, so the bench checks that the reported chain is the same as for an undisturbed walk.

// File: rtl/rwalk_pkg.sv
package rwalk_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_CHK, ST_LEN, ST_B1, ST_B2, ST_DONE, ST_ERR
  } walk_st_e;

  localparam int unsigned HDR_LONG  = 22;
  localparam int unsigned HDR_SHORT = 16;
  localparam int unsigned IMG_BASE  = 13;
  localparam logic [7:0]  PORT_LEN  = 8'd8;

  typedef struct packed {
    logic       is_port;
    logic       dis;
    logic [5:0] idx;
  } ent_hdr_t;
endpackage

// File: rtl/rwalk_bounds.sv
module rwalk_bounds #(
  parameter int unsigned POS_W = 13
) (
  input  logic [POS_W-1:0] pos_i,
  input  logic [POS_W-1:0] end_i,
  input  logic [7:0]       len_i,
  output logic             at_end_o,
  output logic             last_o,
  output logic             over_o
);
  localparam int unsigned W = POS_W + 1;
  logic [W-1:0] pos_x, end_x;

  assign pos_x    = {1'b0, pos_i};
  assign end_x    = {1'b0, end_i};
  assign at_end_o = pos_x >= end_x;
  assign last_o   = (pos_x + W'(1)) == end_x;
  assign over_o   = (len_i == 8'd0) || ((pos_x + W'(len_i)) > end_x);
endmodule

// File: rtl/rwalk_hdr_dec.sv
module rwalk_hdr_dec
  import rwalk_pkg::*;
(
  input  logic [7:0] b1_i,
  input  logic [7:0] len_i,
  input  logic [5:0] max_port_i,
  output ent_hdr_t   hdr_o,
  output logic       skip_o,
  output logic       bad_len_o,
  output logic       need_b2_o
);
  logic live_port;

  assign hdr_o.is_port = b1_i[7];
  assign hdr_o.dis     = b1_i[6];
  assign hdr_o.idx     = b1_i[5:0];
  assign skip_o        = b1_i[7] && (b1_i[5:0] > max_port_i);
  // range filter first, then disabled, then size rule
  assign live_port     = b1_i[7] && !skip_o && !b1_i[6];
  assign bad_len_o     = live_port && (len_i != PORT_LEN);
  assign need_b2_o     = live_port && (len_i == PORT_LEN);
endmodule

// File: rtl/rom_entry_walker.sv
module rom_entry_walker
  import rwalk_pkg::*;
#(
  parameter int unsigned LEN_W = 12,
  localparam int unsigned POS_W = LEN_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             short_hdr_i,
  input  logic [LEN_W-1:0] data_len_i,
  input  logic [5:0]       max_port_i,
  output logic             mem_rd_o,
  output logic [POS_W-1:0] mem_addr_o,
  input  logic [7:0]       mem_data_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             error_o,
  output logic             err_badlen_o,
  output logic             ent_valid_o,
  output logic [POS_W-1:0] ent_pos_o,
  output logic [7:0]       ent_len_o,
  output logic             ent_port_o,
  output logic [5:0]       ent_idx_o,
  output logic             ent_dis_o,
  output logic             ent_link_o,
  output logic             ent_dual_o
);
  localparam int unsigned W = POS_W + 1;

  walk_st_e         st_q;
  logic [POS_W-1:0] pos_q, end_q;
  logic [5:0]       max_q;
  logic [7:0]       len_q;
  ent_hdr_t         hdr_q, hdr_d;
  logic             badlen_q;
  logic             at_end, last_b, over;
  logic             skip, bad_len, need_b2;
  logic             idle_like;

  rwalk_bounds #(.POS_W(POS_W)) u_bounds (
    .pos_i(pos_q), .end_i(end_q), .len_i(mem_data_i),
    .at_end_o(at_end), .last_o(last_b), .over_o(over)
  );

  rwalk_hdr_dec u_dec (
    .b1_i(mem_data_i), .len_i(len_q), .max_port_i(max_q),
    .hdr_o(hdr_d), .skip_o(skip), .bad_len_o(bad_len), .need_b2_o(need_b2)
  );

  assign idle_like = (st_q == ST_IDLE) || (st_q == ST_DONE) || (st_q == ST_ERR);
  assign busy_o    = !idle_like;
  assign done_o    = st_q == ST_DONE;
  assign error_o   = st_q == ST_ERR;
  assign err_badlen_o = badlen_q;

  always_comb begin
    mem_rd_o   = 1'b0;
    mem_addr_o = pos_q;
    unique case (st_q)
      ST_CHK: mem_rd_o = !at_end && !last_b;
      ST_LEN: begin mem_rd_o = 1'b1; mem_addr_o = pos_q + POS_W'(1); end
      ST_B1:  begin mem_rd_o = 1'b1; mem_addr_o = pos_q + POS_W'(2); end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      pos_q       <= '0;
      end_q       <= '0;
      max_q       <= '0;
      len_q       <= '0;
      hdr_q       <= '0;
      badlen_q    <= 1'b0;
      ent_valid_o <= 1'b0;
      ent_pos_o   <= '0;
      ent_len_o   <= '0;
      ent_port_o  <= 1'b0;
      ent_idx_o   <= '0;
      ent_dis_o   <= 1'b0;
      ent_link_o  <= 1'b0;
      ent_dual_o  <= 1'b0;
    end else begin
      ent_valid_o <= 1'b0;
      unique case (st_q)
        ST_IDLE, ST_DONE, ST_ERR: if (start_i) begin
          pos_q    <= short_hdr_i ? POS_W'(HDR_SHORT) : POS_W'(HDR_LONG);
          end_q    <= POS_W'(data_len_i) + POS_W'(IMG_BASE);
          max_q    <= max_port_i;
          badlen_q <= 1'b0;
          st_q     <= ST_CHK;
        end
        ST_CHK: begin
          if (at_end)      st_q <= ST_DONE;
          else if (last_b) st_q <= ST_ERR;
          else             st_q <= ST_LEN;
        end
        ST_LEN: begin
          len_q <= mem_data_i;
          st_q  <= over ? ST_ERR : ST_B1;
        end
        ST_B1: begin
          hdr_q <= hdr_d;
          if (skip) begin
            pos_q <= pos_q + POS_W'(len_q);
            st_q  <= ST_CHK;
          end else if (bad_len) begin
            badlen_q <= 1'b1;
            st_q     <= ST_ERR;
          end else if (need_b2) begin
            st_q <= ST_B2;
          end else begin
            ent_valid_o <= 1'b1;
            ent_pos_o   <= pos_q;
            ent_len_o   <= len_q;
            ent_port_o  <= hdr_d.is_port;
            ent_idx_o   <= hdr_d.idx;
            ent_dis_o   <= hdr_d.dis;
            ent_link_o  <= 1'b0;
            ent_dual_o  <= 1'b0;
            pos_q       <= pos_q + POS_W'(len_q);
            st_q        <= ST_CHK;
          end
        end
        ST_B2: begin
          ent_valid_o <= 1'b1;
          ent_pos_o   <= pos_q;
          ent_len_o   <= len_q;
          ent_port_o  <= hdr_q.is_port;
          ent_idx_o   <= hdr_q.idx;
          ent_dis_o   <= hdr_q.dis;
          ent_link_o  <= mem_data_i[4];
          ent_dual_o  <= mem_data_i[7];
          pos_q       <= pos_q + POS_W'(len_q);
          st_q        <= ST_CHK;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R4
  err_no_report_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    error_o |-> !ent_valid_o);
  // R5
  port_idx_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ent_valid_o && ent_port_o) |-> (ent_idx_o <= max_q));
  // R6
  port_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ent_valid_o && ent_port_o && !ent_dis_o) |-> (ent_len_o == PORT_LEN));
  // R7
  link_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ent_valid_o && !(ent_port_o && !ent_dis_o)) |-> (!ent_link_o && !ent_dual_o));
  // R8
  ent_in_bounds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ent_valid_o |-> (ent_len_o != 8'd0 &&
                     ({1'b0, ent_pos_o} + W'(ent_len_o)) <= {1'b0, end_q}));
  // R9
  done_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> done_o);
  // R9
  err_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (error_o && !start_i) |=> (error_o && $stable(err_badlen_o)));
  // R10
  read_before_use_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_LEN || st_q == ST_B1) |-> $past(mem_rd_o));
endmodule

// File: tb/tb_rom_entry_walker.sv
module tb_rom_entry_walker;
  localparam int CLK_PERIOD = 10;
  localparam int LEN_W = 8;
  localparam int POS_W = LEN_W + 1;
  localparam int MEM_N = 1 << POS_W;
  localparam int MAXE = 128;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, short_hdr = 1'b0;
  logic [LEN_W-1:0] data_len = '0;
  logic [5:0] max_port = '0;
  logic mem_rd;
  logic [POS_W-1:0] mem_addr;
  logic [7:0] mem_q;
  logic busy, done, err, badlen, ev, eport, edis, elink, edual;
  logic [POS_W-1:0] epos;
  logic [7:0] elen;
  logic [5:0] eidx;

  logic [7:0] mem [MEM_N];
  int n_run = 0, n_fail = 0, cycles = 0;

  int got_n;
  int got_pos[MAXE], got_len[MAXE], got_hdr[MAXE], got_ld[MAXE];
  int exp_n, exp_stat;
  int exp_pos[MAXE], exp_len[MAXE], exp_hdr[MAXE], exp_ld[MAXE];

  always #(CLK_PERIOD/2) clk = ~clk;

  always_ff @(posedge clk) if (mem_rd) mem_q <= mem[mem_addr];

  rom_entry_walker #(.LEN_W(LEN_W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .short_hdr_i(short_hdr),
    .data_len_i(data_len), .max_port_i(max_port),
    .mem_rd_o(mem_rd), .mem_addr_o(mem_addr), .mem_data_i(mem_q),
    .busy_o(busy), .done_o(done), .error_o(err), .err_badlen_o(badlen),
    .ent_valid_o(ev), .ent_pos_o(epos), .ent_len_o(elen), .ent_port_o(eport),
    .ent_idx_o(eidx), .ent_dis_o(edis), .ent_link_o(elink), .ent_dual_o(edual)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        chk(1'b0, "R2", "watchdog", cycles, 150000);
        summary();
      end
    end
  end

  task automatic clr_mem();
    for (int i = 0; i < MEM_N; i++) mem[i] = 8'h00;
  endtask

  task automatic put(input int p, input int l, input int b1, input int b2);
    mem[p] = 8'(l); mem[p+1] = 8'(b1); mem[p+2] = 8'(b2);
  endtask

  // Expected walk from the requirements. stat: 0 done, 1 overrun, 2 port size
  task automatic ref_walk(input bit md, input int dl, input int mp);
    int p, e, l, b1, b2;
    bit pt, ds;
    p = md ? 16 : 22;
    e = dl + 13;
    exp_n = 0;
    exp_stat = 0;
    while (p < e) begin
      l = mem[p];
      if (p + 1 == e || l == 0 || p + l > e) begin exp_stat = 1; break; end
      b1 = mem[p+1]; b2 = mem[p+2];
      pt = b1[7]; ds = b1[6];
      if (pt && (b1 & 63) > mp) begin p += l; continue; end
      if (pt && !ds && l != 8) begin exp_stat = 2; break; end
      exp_pos[exp_n] = p;
      exp_len[exp_n] = l;
      exp_hdr[exp_n] = b1;
      exp_ld[exp_n]  = (pt && !ds) ? (((b2 >> 4) & 1) | (((b2 >> 7) & 1) << 1)) : 0;
      exp_n++;
      p += l;
    end
  endtask

  task automatic walk(input bit md, input int dl, input int mp, input bit poke);
    int t;
    got_n = 0;
    @(negedge clk);
    short_hdr = md; data_len = LEN_W'(dl); max_port = 6'(mp); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // R9: start accepted, held flags cleared
    chk(!done && !err, "R9", "flags cleared by start", {done, err}, 0);
    t = 0;
    while (!(done || err) && t < 4000) begin
      if (ev && got_n < MAXE) begin
        got_pos[got_n] = epos;
        got_len[got_n] = elen;
        got_hdr[got_n] = {eport, edis, eidx};
        got_ld[got_n]  = {edual, elink};
        got_n++;
      end
      if (poke && t == 3) begin
        short_hdr = !md; data_len = LEN_W'(dl ^ 8'h55); max_port = 6'(mp + 7);
        start = 1'b1;
      end
      if (poke && t == 4) begin start = 1'b0; short_hdr = md; end
      @(negedge clk);
      t++;
    end
  endtask

  task automatic compare(input bit md, input int dl, input int mp, input string tag);
    int st;
    ref_walk(md, dl, mp);
    st = err ? (badlen ? 2 : 1) : (done ? 0 : 3);
    chk(st == exp_stat, tag, "end status", st, exp_stat);
    chk(got_n == exp_n, "R8", "entry count", got_n, exp_n);
    for (int i = 0; i < exp_n && i < got_n; i++) begin
      chk(got_pos[i] == exp_pos[i], "R8", "entry position", got_pos[i], exp_pos[i]);
      chk(got_len[i] == exp_len[i], "R3", "entry length", got_len[i], exp_len[i]);
      chk(got_hdr[i] == exp_hdr[i], "R3", "type/dis/index", got_hdr[i], exp_hdr[i]);
      chk(got_ld[i] == exp_ld[i], "R7", "dual/link", got_ld[i], exp_ld[i]);
    end
  endtask

  task automatic run(input bit md, input int dl, input int mp, input string tag);
    walk(md, dl, mp, 1'b0);
    compare(md, dl, mp, tag);
  endtask

  initial begin
    int p, l, b1, dl, mp, k;
    bit md;
    clr_mem();
    repeat (3) @(negedge clk);
    // R11
    chk(!busy && !done && !err && !ev, "R11", "reset outputs",
        {busy, done, err, ev}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: empty images in both modes
    run(1'b0, 9, 10, "R2");
    chk(done && got_n == 0, "R2", "empty long header", got_n, 0);
    run(1'b1, 0, 10, "R2");
    chk(done && got_n == 0, "R2", "empty short header", got_n, 0);

    // R1/R3: generic chain, short header
    clr_mem();
    put(16, 4, 8'h01, 0); put(20, 3, 8'h42, 0); put(23, 5, 8'h3f, 8'hff);
    run(1'b1, 15, 10, "R2");
    chk(got_n > 0 && got_pos[0] == 16, "R1", "short header start", got_pos[0], 16);

    // R1/R7: port chain, long header, then disabled odd-size port
    clr_mem();
    put(22, 8, 8'h83, 8'h90); put(30, 8, 8'h84, 8'h10); put(38, 3, 8'hc5, 8'hff);
    run(1'b0, 28, 10, "R6");
    chk(got_n > 0 && got_pos[0] == 22, "R1", "long header start", got_pos[0], 22);
    chk(got_n == 3 && got_ld[0] == 3 && got_ld[1] == 1, "R7", "link bits", got_ld[0], 3);

    // R9: flag held over idle cycles, then back-to-back restart in other mode
    repeat (5) @(negedge clk);
    chk(done, "R9", "done held", done, 1);
    clr_mem();
    put(16, 2, 8'h07, 0);
    run(1'b1, 5, 10, "R9");

    // R5: out-of-range port skipped, even with a wrong size
    clr_mem();
    put(22, 5, 8'h94, 0); put(27, 7, 8'h8b, 0); put(34, 4, 8'h02, 0);
    run(1'b0, 25, 10, "R5");
    chk(got_n == 1 && got_pos[0] == 34, "R5", "skipped ports", got_n, 1);

    // R4: zero length
    clr_mem();
    put(22, 0, 8'h01, 0);
    run(1'b0, 20, 10, "R4");
    chk(err && !badlen && got_n == 0, "R4", "zero length", {err, badlen}, 2);
    // R4: entry at last byte
    clr_mem();
    put(22, 3, 8'h01, 0); mem[25] = 8'd2;
    run(1'b0, 13, 10, "R4");
    chk(err && !badlen && got_n == 1, "R4", "last byte", got_n, 1);
    repeat (4) @(negedge clk);
    chk(err && !badlen, "R9", "error held", {err, badlen}, 2);
    // R4: truncated entry
    clr_mem();
    put(22, 6, 8'h01, 0);
    run(1'b0, 14, 10, "R4");
    chk(err && !badlen && got_n == 0, "R4", "truncated", {err, badlen}, 2);

    // R6: enabled port of size 7
    clr_mem();
    put(22, 4, 8'h01, 0); put(26, 7, 8'h82, 8'h90);
    run(1'b0, 30, 10, "R6");
    chk(err && badlen && got_n == 1, "R6", "port size", {err, badlen}, 3);

    // R9: start during a walk is ignored
    clr_mem();
    put(22, 8, 8'h81, 8'h10); put(30, 3, 8'h05, 0); put(33, 8, 8'h82, 8'h80);
    walk(1'b0, 28, 10, 1'b1);
    compare(1'b0, 28, 10, "R9");

    // Sweep of generated images, both modes
    for (int r = 0; r < 300; r++) begin
      for (int i = 0; i < MEM_N; i++) mem[i] = 8'($urandom);
      md = r[0];
      mp = $urandom_range(0, 20);
      p = md ? 16 : 22;
      k = 0;
      while (p < 200 && k < 40) begin
        b1 = $urandom_range(0, 255);
        if (b1[7] && !b1[6] && $urandom_range(0, 11) != 0) l = 8;
        else l = $urandom_range(2, 9);
        if ($urandom_range(0, 40) == 0) l = 0;
        mem[p] = 8'(l); mem[p+1] = 8'(b1);
        if (l == 0) break;
        p += l; k++;
      end
      dl = p - 13 - (($urandom_range(0, 5) == 0) ? $urandom_range(0, 3) : 0);
      if (dl < 0) dl = 0;
      if (dl > 255) dl = 255;
      run(md, dl, mp, (r % 2 == 0) ? "R4" : "R6");
    end

    summary();
  end
endmodule